// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the controller side of a two-port byte interface through which a host reaches a 256-byte register space inside the controller. One port carries data bytes. The other is read as a status byte and written as a command byte. Every byte the host writes is latched into a one-deep input buffer and marked as either a command or a data byte. A protocol sequencer then consumes that byte and releases the buffer. Results for the host go into a one-deep output buffer, whose full flag tells the host when to read.

Two sequences reach the register space: a read, made of a command byte and an address byte, and a write, made of a command byte, an address byte and a value byte. Two further commands switch a burst-mode flag on and off. A query command answers with an empty-queue code. The register space has a fixed read latency, set by a parameter. A host is expected to poll the input-full flag before each write and the output-full flag before each read of the data port.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 and the data port reads 0x00.
- R2: The status byte is laid out as bit 0 output-full, bit 1 input-full, bit 3 last-byte-was-command, bit 4 burst enabled; bits 2, 5, 6 and 7 always read 0.
- R3: A host write accepted at a clock edge sets input-full from that edge, holds it for exactly one cycle and clears it at the next edge. The last-byte-was-command bit becomes 1 for a write with `host_sel`=1 and 0 for a write with `host_sel`=0.
- R4: Command 0x80 followed by a data byte A loads register A into the data port and sets output-full exactly RD_LAT+1 cycles after the edge that accepted A.
- R5: Command 0x81 followed by data byte A and data byte V stores V into register A and does not set output-full.
- R6: A data-port read (`host_rd`=1 with `host_sel`=0) clears output-full at that edge, and the data port keeps its value. When a result is loaded at the same edge, the load wins.
- R7: Command 0x82 sets the burst bit and 0x83 clears it. No other byte changes it.
- R8: Command 0x84 loads the data port with QUERY_EMPTY (default 0x00) and sets output-full.
- R9: A command byte that arrives during an unfinished read or write sequence ends that sequence. No register is written and no result is delivered for it.
- R10: A command byte that is not 0x80 to 0x84, and a data byte that arrives outside a sequence, are consumed with no effect other than clearing input-full.
- R11: A host write in a cycle where input-full is set is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Port select: 0 data port, 1 command/status port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; only a data-port read has a side effect |
| host_wdata | input | DW | Byte written by the host |
| host_rdata | output | DW | Status byte when host_sel=1, data port when host_sel=0 |

## Verification
The bench goes after the timing of the flags. The input-full flag must drop one cycle after each accepted write. A sequencer that took longer, or never released the flag, would stall the host's polling loop. Output-full must rise exactly RD_LAT+1 cycles after the address byte. A design with a miscounted latency counter would hand the host a byte from the register pipeline before it settled.

The bench also covers three corner cases. A command that arrives while a read is still waiting on the register space must cancel that read; a design that got this wrong would raise output-full with a stale result. A command that interrupts a write must prevent the write; otherwise a following value byte would corrupt a register. A second write while the input buffer is full must be dropped; otherwise the first byte would be overwritten before it is decoded.

// File: rtl/ec_pkg.sv
package ec_pkg;
  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;

  localparam int SB_OBF   = 0;
  localparam int SB_IBF   = 1;
  localparam int SB_CMD   = 3;
  localparam int SB_BURST = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_ADDR,
    SQ_RD_WAIT,
    SQ_WR_ADDR,
    SQ_WR_DATA
  } seq_state_e;
endpackage

// File: rtl/ec_port_decode.sv
module ec_port_decode #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  input  logic          consume,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          burst,
  output logic          ibf,
  output logic          in_is_cmd,
  output logic [DW-1:0] in_byte,
  output logic          obf,
  output logic [DW-1:0] status,
  output logic [DW-1:0] dport
);
  import ec_pkg::*;

  logic          ibf_q, ibf_d, cmd_q, cmd_d, obf_q, obf_d;
  logic [DW-1:0] in_q, in_d, out_q, out_d;
  logic          accept;

  assign accept = host_wr & ~ibf_q;

  always_comb begin
    ibf_d = ibf_q;
    cmd_d = cmd_q;
    in_d  = in_q;
    if (accept) begin
      ibf_d = 1'b1;
      cmd_d = host_sel;
      in_d  = host_wdata;
    end else if (consume) begin
      ibf_d = 1'b0;
    end
    obf_d = obf_q;
    out_d = out_q;
    if (load) begin
      obf_d = 1'b1;
      out_d = load_data;
    end else if (host_rd && !host_sel) begin
      obf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      cmd_q <= 1'b0;
      in_q  <= '0;
      obf_q <= 1'b0;
      out_q <= '0;
    end else begin
      ibf_q <= ibf_d;
      cmd_q <= cmd_d;
      in_q  <= in_d;
      obf_q <= obf_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    status           = '0;
    status[SB_OBF]   = obf_q;
    status[SB_IBF]   = ibf_q;
    status[SB_CMD]   = cmd_q;
    status[SB_BURST] = burst;
  end

  assign ibf       = ibf_q;
  assign in_is_cmd = cmd_q;
  assign in_byte   = in_q;
  assign obf       = obf_q;
  assign dport     = out_q;
endmodule

// File: rtl/ec_sequencer.sv
module ec_sequencer #(
  parameter int              DW          = 8,
  parameter int              AW          = 8,
  parameter int              RD_LAT      = 2,
  parameter logic [DW-1:0]   QUERY_EMPTY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ibf,
  input  logic          in_is_cmd,
  input  logic [DW-1:0] in_byte,
  input  logic [DW-1:0] rf_rdata,
  output logic          consume,
  output logic          load,
  output logic [DW-1:0] load_data,
  output logic          burst,
  output logic          rf_rd,
  output logic          rf_wr,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata
);
  import ec_pkg::*;

  localparam int CW = $clog2(RD_LAT + 1);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          burst_q, burst_d;

  assign consume = ibf;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    burst_d   = burst_q;
    load      = 1'b0;
    load_data = rf_rdata;
    rf_rd     = 1'b0;
    rf_wr     = 1'b0;
    rf_addr   = in_byte[AW-1:0];
    rf_wdata  = in_byte;
    if (ibf && in_is_cmd) begin
      st_d = SQ_IDLE;
      case (in_byte)
        OP_READ:      st_d = SQ_RD_ADDR;
        OP_WRITE:     st_d = SQ_WR_ADDR;
        OP_BURST_ON:  burst_d = 1'b1;
        OP_BURST_OFF: burst_d = 1'b0;
        OP_QUERY: begin
          load      = 1'b1;
          load_data = QUERY_EMPTY;
        end
        default: ;
      endcase
    end else begin
      case (st_q)
        SQ_RD_ADDR: if (ibf) begin
          rf_rd = 1'b1;
          cnt_d = CW'(RD_LAT);
          st_d  = SQ_RD_WAIT;
        end
        SQ_RD_WAIT: if (cnt_q == CW'(1)) begin
          load = 1'b1;
          st_d = SQ_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
        SQ_WR_ADDR: if (ibf) begin
          addr_d = in_byte[AW-1:0];
          st_d   = SQ_WR_DATA;
        end
        SQ_WR_DATA: if (ibf) begin
          rf_wr   = 1'b1;
          rf_addr = addr_q;
          st_d    = SQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      burst_q <= burst_d;
    end
  end

  assign burst = burst_q;
endmodule

// File: rtl/ec_regfile.sv
module ec_regfile #(
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] stage0;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage0 <= '0;
    else if (rd_en) stage0 <= mem[addr];
  end

  generate
    if (RD_LAT > 1) begin : g_pipe
      logic [DW-1:0] pipe [RD_LAT-1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < RD_LAT-1; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= stage0;
          for (int i = 1; i < RD_LAT-1; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign rdata = pipe[RD_LAT-2];
    end else begin : g_direct
      assign rdata = stage0;
    end
  endgenerate
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port #(
  parameter int            DW          = 8,
  parameter int            AW          = 8,
  parameter int            RD_LAT      = 2,
  parameter logic [DW-1:0] QUERY_EMPTY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          ibf_w, cmd_w, obf_w, burst_w, load_w, consume_w;
  logic [DW-1:0] in_byte_w, load_data_w, status_w, dport_w, rf_rdata_w, rf_wdata_w;
  logic          rf_rd_w, rf_wr_w;
  logic [AW-1:0] rf_addr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ec_port_decode #(.DW(DW)) u_port (
    .clk(clk), .rst_n(rst_sync_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .consume(consume_w), .load(load_w), .load_data(load_data_w), .burst(burst_w),
    .ibf(ibf_w), .in_is_cmd(cmd_w), .in_byte(in_byte_w), .obf(obf_w),
    .status(status_w), .dport(dport_w)
  );

  ec_sequencer #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT), .QUERY_EMPTY(QUERY_EMPTY)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .ibf(ibf_w), .in_is_cmd(cmd_w), .in_byte(in_byte_w), .rf_rdata(rf_rdata_w),
    .consume(consume_w), .load(load_w), .load_data(load_data_w), .burst(burst_w),
    .rf_rd(rf_rd_w), .rf_wr(rf_wr_w), .rf_addr(rf_addr_w), .rf_wdata(rf_wdata_w)
  );

  ec_regfile #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT)) u_rf (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_en(rf_rd_w), .wr_en(rf_wr_w), .addr(rf_addr_w), .wdata(rf_wdata_w),
    .rdata(rf_rdata_w)
  );

  assign host_rdata = host_sel ? status_w : dport_w;
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_rd,
  input logic          ibf,
  input logic          obf,
  input logic          burst,
  input logic          load,
  input logic [DW-1:0] status
);
  a_r3_ibf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ibf) |=> ibf);

  a_r3_ibf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ibf |=> !ibf);

  a_r11_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && ibf) |=> !ibf);

  a_r6_read_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && !load) |=> !obf);

  a_r4_load_sets_obf: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> obf);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:5] == 3'b000) && (status[2] == 1'b0));

  a_r7_burst_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(burst) |-> $past(ibf));
endmodule

bind ec_host_port ec_host_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .ibf(ibf_w), .obf(obf_w), .burst(burst_w),
  .load(load_w), .status(status_w)
);

// File: tb/ec_host_port_tb.sv
`timescale 1ns/1ps
module ec_host_port_tb;
  localparam int LAT = 2;

  logic       clk, rst_n, host_sel, host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic [7:0] mdl [256];
  logic       mburst;
  int         n_chk, n_fail, cyc;

  ec_host_port #(.DW(8), .AW(8), .RD_LAT(LAT), .QUERY_EMPTY(8'h00)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status(logic obf, logic ibf, logic cmd, logic burst);
    exp_status = {3'b000, burst, cmd, 1'b0, ibf, obf};
  endfunction

  function automatic logic [7:0] fill_val(int a);
    fill_val = 8'(a * 37 + 11);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic peek_status(output logic [7:0] s);
    host_sel = 1'b1;
    #1 s = host_rdata;
  endtask

  task automatic wr_byte(logic sel, logic [7:0] v);
    logic [7:0] s;
    peek_status(s);
    while (s[1]) begin tick(); peek_status(s); end
    host_sel = sel; host_wdata = v; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic rd_data(output logic [7:0] v);
    logic [7:0] s;
    peek_status(s);
    while (!s[0]) begin tick(); peek_status(s); end
    host_sel = 1'b0; host_rd = 1'b1;
    #1 v = host_rdata;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] v);
    wr_byte(1'b1, 8'h81); wr_byte(1'b0, a); wr_byte(1'b0, v);
    mdl[a] = v;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [7:0] v);
    wr_byte(1'b1, 8'h80); wr_byte(1'b0, a); rd_data(v);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [7:0] s, v;
    int k;
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0; mburst = 1'b0;
    rst_n = 1'b0; host_sel = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    peek_status(s); check("R1 status", s, 8'h00);
    host_sel = 1'b0; #1 check("R1 data port", host_rdata, 8'h00);

    // R3 + R7: burst on, flag timing
    wr_byte(1'b1, 8'h82);
    peek_status(s); check("R3 ibf set cmd", s, exp_status(0, 1, 1, 0));
    tick(); peek_status(s); check("R7 burst on / R3 ibf clear", s, exp_status(0, 0, 1, 1));
    // R10: stray data byte in idle
    wr_byte(1'b0, 8'h55);
    peek_status(s); check("R3 ibf set data", s, exp_status(0, 1, 0, 1));
    tick(); peek_status(s); check("R10 stray data ignored", s, exp_status(0, 0, 0, 1));
    wr_byte(1'b1, 8'h83); tick();
    peek_status(s); check("R7 burst off", s, exp_status(0, 0, 1, 0));

    // R5: fill register space
    for (int a = 0; a < 256; a++) reg_write(8'(a), fill_val(a));
    tick(); peek_status(s); check("R5 no obf after writes", s, exp_status(0, 0, 0, 0));

    // R4: exact latency
    wr_byte(1'b1, 8'h80); wr_byte(1'b0, 8'h17);
    k = 0; peek_status(s);
    while (!s[0] && k < 50) begin tick(); k++; peek_status(s); end
    check("R4 latency", 8'(k), 8'(LAT + 1));
    host_sel = 1'b0; host_rd = 1'b1; #1 v = host_rdata;
    check("R4 read value", v, fill_val(8'h17));
    tick(); host_rd = 1'b0;
    peek_status(s); check("R6 obf cleared", s[0], 1'b0);
    host_sel = 1'b0; #1 check("R6 data held", host_rdata, fill_val(8'h17));

    // R8: query
    wr_byte(1'b1, 8'h84); tick();
    peek_status(s); check("R8 query obf", s[0], 1'b1);
    rd_data(v); check("R8 query code", v, 8'h00);

    // R9: write aborted by read command
    wr_byte(1'b1, 8'h81); wr_byte(1'b0, 8'h20);
    wr_byte(1'b1, 8'h80); wr_byte(1'b0, 8'h20);
    rd_data(v); check("R9 aborted write", v, mdl[8'h20]);

    // R9: read aborted during the latency wait
    wr_byte(1'b1, 8'h80); wr_byte(1'b0, 8'h30); wr_byte(1'b1, 8'h83);
    repeat (6) tick();
    peek_status(s); check("R9 aborted read no obf", s, exp_status(0, 0, 1, 0));

    // R10: unknown command inside write, then value byte
    wr_byte(1'b1, 8'h81); wr_byte(1'b0, 8'h40); wr_byte(1'b1, 8'h5A);
    tick(); peek_status(s); check("R10 unknown cmd", s, exp_status(0, 0, 1, 0));
    wr_byte(1'b0, 8'h99); tick();
    reg_read(8'h40, v); check("R10 register untouched", v, mdl[8'h40]);

    // R11: back-to-back writes, second dropped
    peek_status(s);
    host_sel = 1'b1; host_wdata = 8'h82; host_wr = 1'b1; tick();
    host_wdata = 8'h83; tick(); host_wr = 1'b0; tick();
    peek_status(s); check("R11 second byte dropped", s, exp_status(0, 0, 1, 1));
    mburst = 1'b1;

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] a, d;
      op = int'($urandom % 3);
      a  = 8'($urandom);
      d  = 8'($urandom);
      if (op == 0) begin
        reg_write(a, d);
      end else if (op == 1) begin
        reg_read(a, v); check("R4 random read", v, mdl[a]);
      end else begin
        mburst = d[0];
        wr_byte(1'b1, d[0] ? 8'h82 : 8'h83); tick();
        peek_status(s); check("R7 random burst", s[4], mburst);
      end
    end

    summary();
  end
endmodule